// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Engine

This block refills one cache line after a miss. It takes the word address that missed and reads the eight words of that line from memory, one word at a time. The word the processor was waiting for is handed on in the same cycle that memory returns it. The processor can then go on working while the rest of the line keeps arriving. Each returned word is written into a line buffer. Words that have already landed can be read back from that buffer while the fill is still running. A word that has not landed yet holds the read off.

The parameter `CRIT_FIRST` picks the fetch order:
- With `CRIT_FIRST = 1`, the fill starts at the missed word and wraps around the end of the line.
- With `CRIT_FIRST = 0`, the line is fetched from offset 0 upward. The needed word is still forwarded the moment it shows up (early restart).

The controller has two states:
- `ST_IDLE` accepts a miss. The transition *accept* (`miss_valid` high while idle) moves it to `ST_FILL`.
- `ST_FILL` holds the memory request. The transition *step* stays in `ST_FILL` on each returned word except the last. The transition *finish* returns to `ST_IDLE` on the last returned word.

Top module: `cwf_line_fill`

## Requirements
- R1: With `CRIT_FIRST = 1`, the first memory request after a miss is accepted carries the missed word's offset, which is the low 3 bits of `miss_addr`.
- R2: `cpu_valid` is high in exactly one cycle per fill. That cycle is the one in which `mem_rvalid` returns the word whose offset equals the missed offset, and in it `cpu_data` equals `mem_rdata`.
- R3: With `CRIT_FIRST = 1`, `cpu_valid` comes with the first returned word. At that point `busy` is high and seven words are still to come.
- R4: With `CRIT_FIRST = 0`, the offsets are fetched in the order 0,1,...,7. `cpu_valid` still rises when the missed offset returns.
- R5: With `CRIT_FIRST = 1`, the k-th returned word has offset (miss offset + k) mod 8. `mem_addr` is always the line base (the upper bits of `miss_addr`) followed by the 3-bit offset, and the address is held until `mem_rvalid`.
- R6: `line_valid` goes low in the cycle after a miss is accepted. It goes high in the cycle after the 8th word returns. After that, every offset reads back with `rd_hit` high and the returned data.
- R7: While `busy` is high, `miss_ready` is low and `miss_valid` is ignored. `busy` is high from the cycle after acceptance until the cycle after the last word returns.
- R8: A read (`rd_req` with `rd_off`) gives `rd_hit` high and the stored word on `rd_data` if that word returned in an earlier cycle. Otherwise it gives `rd_stall` high and `rd_hit` low.
- R9: After reset, the following hold:
  - `busy`, `line_valid`, `mem_req` and `cpu_valid` are low.
  - `miss_ready` is high.
  - Any read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_addr | input | ADDR_W | Word address that missed |
| miss_ready | output | 1 | A miss can be accepted this cycle |
| busy | output | 1 | A fill is in progress |
| line_valid | output | 1 | All words of the line are present |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Word address requested from memory |
| mem_rvalid | input | 1 | Memory returns the word for `mem_addr` |
| mem_rdata | input | DATA_W | Returned word |
| cpu_valid | output | 1 | Missed word delivered to the processor |
| cpu_data | output | DATA_W | Missed word |
| rd_req | input | 1 | Processor read of the line buffer |
| rd_off | input | OFF_W | Word offset of that read |
| rd_hit | output | 1 | Read served this cycle |
| rd_stall | output | 1 | Read must wait |
| rd_data | output | DATA_W | Data of a served read |

## Verification
The hardest condition to reach is a processor read that lands on a word in the same cycle memory returns that word, or one cycle later. The first must stall and the second must hit. To create it, the bench drives a read in every fill cycle with an offset that rotates through the line. It does this for every missed offset and for memory latencies of zero to two cycles, so every pairing of read offset with arrival position comes up in both fetch orders. A second miss is also presented in mid-fill, and the bench confirms that it neither changes the line address nor restarts the fill.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/cwf_order_gen.sv
module cwf_order_gen #(
    parameter int WORDS      = 8,
    parameter int CRIT_FIRST = 1,
    parameter int OFF_W      = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] miss_off,
    input  logic             step,
    output logic [OFF_W-1:0] cur_off,
    output logic             last
);
    localparam int CNT_W = OFF_W + 1;

    logic [OFF_W-1:0] start_off;
    logic [CNT_W-1:0] taken;

    generate
        if (CRIT_FIRST != 0) begin : g_wrap
            assign start_off = miss_off;
        end else begin : g_seq
            assign start_off = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_off <= '0;
            taken   <= '0;
        end else if (load) begin
            cur_off <= start_off;
            taken   <= '0;
        end else if (step) begin
            cur_off <= (cur_off == OFF_W'(WORDS - 1)) ? '0 : cur_off + 1'b1;
            taken   <= taken + 1'b1;
        end
    end

    assign last = (taken == CNT_W'(WORDS - 1));
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_arrived
);
    logic [DATA_W-1:0] store [WORDS];
    logic [WORDS-1:0]  arrived;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_off] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            arrived <= '0;
        end else if (wr_en) begin
            arrived[wr_off] <= 1'b1;
        end
    end

    assign rd_data    = store[rd_off];
    assign rd_arrived = arrived[rd_off];
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int WORDS      = 8,
    parameter int CRIT_FIRST = 1,
    parameter int OFF_W      = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              busy,
    output logic              line_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data,
    input  logic              rd_req,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              rd_hit,
    output logic              rd_stall,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BASE_W = ADDR_W - OFF_W;

    fill_state_e       state, state_nx;
    logic [BASE_W-1:0] line_base;
    logic [OFF_W-1:0]  need_off;
    logic [OFF_W-1:0]  cur_off;
    logic              last_word;
    logic              accept;
    logic              take;
    logic              arrived;

    assign accept = (state == ST_IDLE) && miss_valid;
    assign take   = (state == ST_FILL) && mem_rvalid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_FILL;
            ST_FILL: if (take && last_word) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            line_base  <= '0;
            need_off   <= '0;
            line_valid <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                line_base  <= miss_addr[ADDR_W-1:OFF_W];
                need_off   <= miss_addr[OFF_W-1:0];
                line_valid <= 1'b0;
            end else if (take && last_word) begin
                line_valid <= 1'b1;
            end
        end
    end

    always_comb begin
        miss_ready = 1'b0;
        busy       = 1'b0;
        mem_req    = 1'b0;
        cpu_valid  = 1'b0;
        unique case (state)
            ST_IDLE: miss_ready = 1'b1;
            ST_FILL: begin
                busy      = 1'b1;
                mem_req   = 1'b1;
                cpu_valid = mem_rvalid && (cur_off == need_off);
            end
        endcase
        mem_addr = {line_base, cur_off};
        cpu_data = mem_rdata;
        rd_hit   = rd_req && arrived;
        rd_stall = rd_req && !arrived;
    end

    cwf_order_gen #(
        .WORDS(WORDS), .CRIT_FIRST(CRIT_FIRST), .OFF_W(OFF_W)
    ) u_order (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .miss_off(miss_addr[OFF_W-1:0]), .step(take),
        .cur_off(cur_off), .last(last_word)
    );

    cwf_line_buf #(
        .WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .wr_en(take), .wr_off(cur_off), .wr_data(mem_rdata),
        .rd_off(rd_off), .rd_data(rd_data), .rd_arrived(arrived)
    );
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int WORDS      = 8,
    parameter int CRIT_FIRST = 1,
    parameter int OFF_W      = $clog2(WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              miss_ready,
    input logic              busy,
    input logic              line_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              cpu_valid,
    input logic [DATA_W-1:0] cpu_data,
    input logic              rd_req,
    input logic              rd_hit,
    input logic              rd_stall
);
    logic [ADDR_W-1:0] cap_addr;
    logic [OFF_W:0]    got;
    logic [OFF_W-1:0]  moff;

    assign moff = mem_addr[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            got      <= '0;
        end else if (miss_valid && miss_ready) begin
            cap_addr <= miss_addr;
            got      <= '0;
        end else if (busy && mem_rvalid) begin
            got <= got + 1'b1;
        end
    end

    // R1 and R4: first requested offset
    a_r1_first_offset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> moff == ((CRIT_FIRST != 0) ? cap_addr[OFF_W-1:0] : '0));

    a_r5_next_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy && mem_rvalid)) |->
        moff == (($past(moff) == OFF_W'(WORDS - 1)) ? '0 : $past(moff) + 1'b1));

    a_r5_held_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy && !mem_rvalid)) |-> $stable(mem_addr));

    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid && moff == cap_addr[OFF_W-1:0]) |->
        (cpu_valid && cpu_data == mem_rdata));

    a_r2_only_needed: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (busy && mem_rvalid && moff == cap_addr[OFF_W-1:0]));

    a_r7_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!miss_ready && mem_addr[ADDR_W-1:OFF_W] == cap_addr[ADDR_W-1:OFF_W]));

    a_r7_busy_to_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (line_valid && got == (OFF_W + 1)'(WORDS)));

    a_r6_valid_after_all: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> got == (OFF_W + 1)'(WORDS));

    a_r8_hit_or_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_hit != rd_stall));

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (!rd_hit && !rd_stall));
endmodule

bind cwf_line_fill cwf_line_fill_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
    .CRIT_FIRST(CRIT_FIRST), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .busy(busy), .line_valid(line_valid),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .rd_req(rd_req),
    .rd_hit(rd_hit), .rd_stall(rd_stall)
);

// File: tb/sim_cwf_line_fill.sv
module sim_mem_model (
    input  logic        clk,
    input  logic        rst_n,
    input  int          lat,
    input  logic        req,
    input  logic [11:0] addr,
    output logic        rvalid,
    output logic [31:0] rdata
);
    int wcnt;
    assign rvalid = req && (wcnt == lat);
    assign rdata  = {4'hA, addr, 4'h5, ~addr};
    always_ff @(posedge clk) begin
        if (!rst_n || rvalid || !req) wcnt <= 0;
        else wcnt <= wcnt + 1;
    end
endmodule

module sim_cwf_line_fill;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [11:0] miss_addr = '0;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_off = '0;
    int          lat = 0;

    logic        mready [2];
    logic        busy   [2];
    logic        lvalid [2];
    logic        mreq   [2];
    logic [11:0] maddr  [2];
    logic        mrv    [2];
    logic [31:0] mrd    [2];
    logic        cpuv   [2];
    logic [31:0] cpud   [2];
    logic        rhit   [2];
    logic        rstall [2];
    logic [31:0] rdat   [2];

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cwf_line_fill #(.ADDR_W(12), .DATA_W(32), .WORDS(8), .CRIT_FIRST(1)) u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_ready(mready[0]), .busy(busy[0]), .line_valid(lvalid[0]),
        .mem_req(mreq[0]), .mem_addr(maddr[0]), .mem_rvalid(mrv[0]), .mem_rdata(mrd[0]),
        .cpu_valid(cpuv[0]), .cpu_data(cpud[0]), .rd_req(rd_req), .rd_off(rd_off),
        .rd_hit(rhit[0]), .rd_stall(rstall[0]), .rd_data(rdat[0])
    );

    cwf_line_fill #(.ADDR_W(12), .DATA_W(32), .WORDS(8), .CRIT_FIRST(0)) u1 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_ready(mready[1]), .busy(busy[1]), .line_valid(lvalid[1]),
        .mem_req(mreq[1]), .mem_addr(maddr[1]), .mem_rvalid(mrv[1]), .mem_rdata(mrd[1]),
        .cpu_valid(cpuv[1]), .cpu_data(cpud[1]), .rd_req(rd_req), .rd_off(rd_off),
        .rd_hit(rhit[1]), .rd_stall(rstall[1]), .rd_data(rdat[1])
    );

    sim_mem_model m0 (.clk(clk), .rst_n(rst_n), .lat(lat), .req(mreq[0]),
        .addr(maddr[0]), .rvalid(mrv[0]), .rdata(mrd[0]));
    sim_mem_model m1 (.clk(clk), .rst_n(rst_n), .lat(lat), .req(mreq[1]),
        .addr(maddr[1]), .rvalid(mrv[1]), .rdata(mrd[1]));

    function automatic logic [31:0] word_of(logic [11:0] a);
        return {4'hA, a, 4'h5, ~a};
    endfunction

    task automatic chk(bit ok, string req, int mode, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s mode%0d: actual %0h expected %0h", req, mode, act, exp);
        end
    endtask

    task automatic run_trial(int off, int lat_i, logic [11:0] base);
        int   k    [2];
        bit   seen [2];
        logic [7:0] mask [2];
        int   start;
        int   c;
        logic [11:0] maddr_v;
        @(negedge clk);
        lat = lat_i;
        rd_req = 1'b0;
        miss_valid = 1'b1;
        miss_addr = base | 12'(off);
        @(negedge clk);
        miss_valid = 1'b0;
        for (int m = 0; m < 2; m++) begin
            k[m] = 0; seen[m] = 1'b0; mask[m] = '0;
        end
        c = 0;
        while ((busy[0] || busy[1]) && c < 200) begin
            rd_req = 1'b1;
            rd_off = 3'((c * 3 + off) % 8);
            miss_valid = (c == 2);
            miss_addr = (c == 2) ? (base ^ 12'h100) : (base | 12'(off));
            #1;
            for (int m = 0; m < 2; m++) begin
                start = (m == 0) ? off : 0;
                if (busy[m]) begin
                    chk(mready[m] == 1'b0, "R7 ready low", m, mready[m], 0);
                    chk(lvalid[m] == 1'b0, "R6 valid low in fill", m, lvalid[m], 0);
                    chk(rhit[m] == mask[m][rd_off], "R8 hit", m, rhit[m], mask[m][rd_off]);
                    chk(rstall[m] == !mask[m][rd_off], "R8 stall", m, rstall[m], !mask[m][rd_off]);
                    if (mask[m][rd_off])
                        chk(rdat[m] == word_of(base | 12'(rd_off)), "R8 data", m,
                            rdat[m], word_of(base | 12'(rd_off)));
                    if (mrv[m]) begin
                        maddr_v = maddr[m];
                        chk(maddr_v[11:3] == base[11:3], "R7 base kept", m, maddr_v, base);
                        if (m == 0)
                            chk(int'(maddr_v[2:0]) == (start + k[m]) % 8,
                                (k[m] == 0) ? "R1 first" : "R5 order", m,
                                maddr_v[2:0], (start + k[m]) % 8);
                        else
                            chk(int'(maddr_v[2:0]) == k[m], "R4 order", m, maddr_v[2:0], k[m]);
                        chk(cpuv[m] == (int'(maddr_v[2:0]) == off), "R2 valid", m,
                            cpuv[m], int'(maddr_v[2:0]) == off);
                        if (cpuv[m]) begin
                            chk(cpud[m] == word_of(base | 12'(off)), "R2 data", m,
                                cpud[m], word_of(base | 12'(off)));
                            if (m == 0) chk(k[m] == 0, "R3 early release", m, k[m], 0);
                            else chk(k[m] == off, "R4 release", m, k[m], off);
                            seen[m] = 1'b1;
                        end
                        mask[m][maddr_v[2:0]] = 1'b1;
                        k[m]++;
                    end else begin
                        chk(cpuv[m] == 1'b0, "R2 quiet", m, cpuv[m], 0);
                    end
                end
            end
            @(negedge clk);
            c++;
        end
        miss_valid = 1'b0;
        #1;
        for (int m = 0; m < 2; m++) begin
            chk(k[m] == 8, "R7 words per fill", m, k[m], 8);
            chk(seen[m], "R2 delivered once", m, seen[m], 1);
            chk(lvalid[m] == 1'b1, "R6 valid after fill", m, lvalid[m], 1);
            chk(busy[m] == 1'b0, "R7 busy ends", m, busy[m], 0);
        end
        for (int o = 0; o < 8; o++) begin
            rd_off = 3'(o);
            #1;
            for (int m = 0; m < 2; m++) begin
                chk(rhit[m] == 1'b1, "R6 hit after fill", m, rhit[m], 1);
                chk(rdat[m] == word_of(base | 12'(o)), "R6 line data", m,
                    rdat[m], word_of(base | 12'(o)));
            end
        end
        rd_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_req = 1'b1;
        rd_off = 3'd3;
        #1;
        for (int m = 0; m < 2; m++) begin
            chk(busy[m] == 1'b0, "R9 busy", m, busy[m], 0);
            chk(lvalid[m] == 1'b0, "R9 line_valid", m, lvalid[m], 0);
            chk(mreq[m] == 1'b0, "R9 mem_req", m, mreq[m], 0);
            chk(cpuv[m] == 1'b0, "R9 cpu_valid", m, cpuv[m], 0);
            chk(mready[m] == 1'b1, "R9 miss_ready", m, mready[m], 1);
            chk(rstall[m] == 1'b1 && rhit[m] == 1'b0, "R9 read stalls", m, rstall[m], 1);
        end
        rd_req = 1'b0;
        for (int l = 0; l < 3; l++) begin
            for (int o = 0; o < 8; o++) begin
                run_trial(o, l, 12'((l * 8 + o) * 8 + 16));
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule